// File: doc/BRIEF.md
# Load/Store Port Memory Adapter

This block is the memory end of a processor load/store port. A requester raises a load or a store strobe together with an address, an address-valid flag, an access length and a virtual-mode bit. The block accepts the address and then serves the access from a small internal memory. The memory is byte addressable and organised as rows of 64 bits. Store data arrives with a valid flag that is high for one cycle. A load ends either with a one-cycle load-valid pulse carrying the data or with a one-cycle exception pulse. An exception is raised for an access that would run past the end of its row or that has an illegal length.

Data is packed little-endian by byte lane. The byte at the lowest address is in bits 7:0 of the lane group. A store shifts its low bytes up into the addressed lanes. A load shifts the addressed lanes down and zero-extends the result. The virtual-mode bit is captured when the address is accepted and presented unchanged on an output. No translation takes place.

The controller is a state machine with these states:
- **ST_IDLE**: not busy.
- **ST_ADDR**: address acknowledged. From here it goes to ST_FAULT on a bad access, to ST_READ for a load, to ST_HOLD for a store whose data arrives in this cycle, and to ST_WDATA otherwise.
- **ST_READ**: the row is read. It always goes to ST_LDVAL.
- **ST_LDVAL**: load-valid is raised. It goes to ST_HOLD.
- **ST_WDATA**: waits for the store data. It goes to ST_HOLD when the data arrives.
- **ST_FAULT**: the exception flag is raised. It goes to ST_HOLD.
- **ST_HOLD**: waits until the requester lets go. It goes to ST_IDLE when both strobes and address-valid are low.

Top module: `lsport_mem_adapter`

## Requirements
- R1: After reset busy, address-accepted, load-valid and the exception flag are low, and every byte of the 16-row memory reads as zero.
- R2: When address-valid and a strobe are high while the block is idle, address-accepted goes high for exactly one cycle, the cycle after the request is seen. Busy is high in that cycle.
- R3: A store writes only the lanes from offset addr[2:0] up to offset+len-1. Data byte i lands in lane offset+i (bits 8*(offset+i)+7 down to 8*(offset+i)). The data is captured in the cycle its valid flag is high, and the other lanes of the row are unchanged.
- R4: For a legal load, load-valid is high for exactly one cycle, two cycles after address-accepted. In that cycle the load data holds lanes offset to offset+len-1 shifted down to bit 0 and zero-extended. The load data reads zero whenever load-valid is low.
- R5: Memory is little-endian: a 2-byte store of 0xbeef at address 4 followed by 0xf00f at address 6 reads back as 0xf00fbeef from a 4-byte load at address 4.
- R6: An access whose offset plus length exceeds 8, or whose length is not 1, 2, 4 or 8, raises the exception flag for exactly one cycle, the cycle after address-accepted. It never raises load-valid and leaves the memory unchanged.
- R7: After an access completes, busy stays high until load strobe, store strobe and address-valid are all low. Busy falls in the following cycle.
- R8: The virtual-mode output equals the mode bit sampled with the accepted request and holds it while the access is in progress.
- R9: Address bits 6:3 select the row, and address bits 47:7 are ignored, so addresses differing only in those bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req_i | input | 1 | Load strobe |
| st_req_i | input | 1 | Store strobe |
| len_i | input | 4 | Access length in bytes (1, 2, 4, 8) |
| virt_i | input | 1 | Mode bit, 1 virtual, 0 real |
| addr_i | input | 48 | Byte address |
| addr_vld_i | input | 1 | Address valid |
| st_data_i | input | 64 | Store data, low bytes used |
| st_vld_i | input | 1 | Store data valid, one cycle |
| busy_o | output | 1 | Access in progress |
| addr_ack_o | output | 1 | Address accepted, one cycle |
| ld_data_o | output | 64 | Load data, zero-extended |
| ld_vld_o | output | 1 | Load data valid, one cycle |
| exc_o | output | 1 | Exception, one cycle |
| virt_o | output | 1 | Captured mode bit |

## Verification
The bench sweeps every start offset against every legal length and stores a distinct pattern for each pair. After each store it reads the whole row back, so a wrong byte-enable mask or lane shift shows up as a clobbered neighbour byte. It then reloads the same offset and length, so a missing zero-extension leaks upper bytes into the result. Row-crossing and illegal-length accesses must pulse the exception flag and leave the row intact; a design that clipped the access instead would corrupt it or return partial data. Aliased high address bits, the little-endian halfword example and busy being held by lingering strobes are each probed, since a design that compared full addresses or dropped busy on completion would fail them.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_READ,
        ST_LDVAL,
        ST_WDATA,
        ST_FAULT,
        ST_HOLD
    } lsp_state_e;

endpackage

// File: rtl/lsp_lane_align.sv
module lsp_lane_align #(
    parameter int DATA_W = 64,
    parameter int LANES  = DATA_W / 8,
    parameter int OFS_W  = $clog2(LANES),
    parameter int LEN_W  = OFS_W + 1
) (
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] st_data_i,
    input  logic [DATA_W-1:0] rd_row_i,
    output logic [LANES-1:0]  be_o,
    output logic [DATA_W-1:0] wr_row_o,
    output logic [DATA_W-1:0] ld_data_o,
    output logic              fault_o
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0]  end_pos;
    logic              len_pow2;
    logic [DATA_W-1:0] shifted;

    assign end_pos  = SUM_W'(ofs_i) + SUM_W'(len_i);
    assign len_pow2 = (len_i != '0) && ((len_i & (len_i - 1'b1)) == '0)
                      && (len_i <= LEN_W'(LANES));
    assign fault_o  = !len_pow2 || (end_pos > SUM_W'(LANES));

    assign wr_row_o = st_data_i << {ofs_i, 3'b000};
    assign shifted  = rd_row_i >> {ofs_i, 3'b000};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be_o[i] = (SUM_W'(i) >= SUM_W'(ofs_i)) && (SUM_W'(i) < end_pos);
        assign ld_data_o[8*i +: 8] = (SUM_W'(i) < SUM_W'(len_i)) ? shifted[8*i +: 8] : 8'h00;
    end

endmodule

// File: rtl/lsp_row_mem.sv
module lsp_row_mem #(
    parameter int DATA_W = 64,
    parameter int ROWS   = 16,
    parameter int LANES  = DATA_W / 8,
    parameter int ROW_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [DATA_W-1:0] wr_row_i,
    output logic [DATA_W-1:0] rd_row_o
);
    logic [DATA_W-1:0] store_q [ROWS];

    for (genvar l = 0; l < LANES; l++) begin : g_wlane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < ROWS; r++) begin
                    store_q[r][8*l +: 8] <= 8'h00;
                end
            end else if (wr_en_i && be_i[l]) begin
                store_q[row_i][8*l +: 8] <= wr_row_i[8*l +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_row_o <= '0;
        end else if (rd_en_i) begin
            rd_row_o <= store_q[row_i];
        end
    end

endmodule

// File: rtl/lsp_ctrl.sv
module lsp_ctrl
    import lsp_pkg::*;
#(
    parameter int OFS_W = 3,
    parameter int LEN_W = 4,
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_req_i,
    input  logic             st_req_i,
    input  logic             addr_vld_i,
    input  logic             st_vld_i,
    input  logic             virt_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             fault_i,
    output logic             busy_o,
    output logic             addr_ack_o,
    output logic             ld_vld_o,
    output logic             exc_o,
    output logic             rd_en_o,
    output logic             wr_en_o,
    output logic             virt_o,
    output logic [OFS_W-1:0] ofs_o,
    output logic [LEN_W-1:0] len_o,
    output logic [ROW_W-1:0] row_o
);
    lsp_state_e state_q, state_d;
    logic       is_ld_q;
    logic       start;
    logic       released;

    assign start    = (ld_req_i || st_req_i) && addr_vld_i;
    assign released = !ld_req_i && !st_req_i && !addr_vld_i;

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_ld_q <= 1'b0;
            virt_o  <= 1'b0;
            ofs_o   <= '0;
            len_o   <= '0;
            row_o   <= '0;
        end else if (state_q == ST_IDLE && start) begin
            is_ld_q <= ld_req_i;
            virt_o  <= virt_i;
            ofs_o   <= ofs_i;
            len_o   <= len_i;
            row_o   <= row_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ADDR;
            ST_ADDR: begin
                if (fault_i)       state_d = ST_FAULT;
                else if (is_ld_q)  state_d = ST_READ;
                else if (st_vld_i) state_d = ST_HOLD;
                else               state_d = ST_WDATA;
            end
            ST_READ:  state_d = ST_LDVAL;
            ST_LDVAL: state_d = ST_HOLD;
            ST_WDATA: if (st_vld_i) state_d = ST_HOLD;
            ST_FAULT: state_d = ST_HOLD;
            ST_HOLD:  if (released) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        addr_ack_o = (state_q == ST_ADDR);
        rd_en_o    = (state_q == ST_READ);
        ld_vld_o   = (state_q == ST_LDVAL);
        exc_o      = (state_q == ST_FAULT);
        wr_en_o    = st_vld_i && !is_ld_q && !fault_i &&
                     ((state_q == ST_ADDR) || (state_q == ST_WDATA));
    end

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack_o |=> !addr_ack_o);

    // R6
    exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |=> !exc_o);

    // R6
    exc_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_o && ld_vld_o));

    // R4
    ldvld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld_o |=> !ld_vld_o);

    // R4
    ldvld_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld_o |-> $past(addr_ack_o, 2));

    // R7
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(released));

    // R8
    virt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack_o |-> (virt_o == $past(virt_i)));

endmodule

// File: rtl/lsport_mem_adapter.sv
module lsport_mem_adapter #(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64,
    parameter int ROWS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req_i,
    input  logic              st_req_i,
    input  logic [3:0]        len_i,
    input  logic              virt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_vld_i,
    input  logic [DATA_W-1:0] st_data_i,
    input  logic              st_vld_i,
    output logic              busy_o,
    output logic              addr_ack_o,
    output logic [DATA_W-1:0] ld_data_o,
    output logic              ld_vld_o,
    output logic              exc_o,
    output logic              virt_o
);
    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);
    localparam int LEN_W = OFS_W + 1;
    localparam int ROW_W = $clog2(ROWS);

    logic [OFS_W-1:0]  ofs_q;
    logic [LEN_W-1:0]  len_q;
    logic [ROW_W-1:0]  row_q;
    logic              fault;
    logic              rd_en, wr_en;
    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] wr_row, rd_row, aligned;

    lsp_ctrl #(.OFS_W(OFS_W), .LEN_W(LEN_W), .ROW_W(ROW_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_req_i   (ld_req_i),
        .st_req_i   (st_req_i),
        .addr_vld_i (addr_vld_i),
        .st_vld_i   (st_vld_i),
        .virt_i     (virt_i),
        .ofs_i      (addr_i[OFS_W-1:0]),
        .len_i      (LEN_W'(len_i)),
        .row_i      (addr_i[OFS_W +: ROW_W]),
        .fault_i    (fault),
        .busy_o     (busy_o),
        .addr_ack_o (addr_ack_o),
        .ld_vld_o   (ld_vld_o),
        .exc_o      (exc_o),
        .rd_en_o    (rd_en),
        .wr_en_o    (wr_en),
        .virt_o     (virt_o),
        .ofs_o      (ofs_q),
        .len_o      (len_q),
        .row_o      (row_q)
    );

    lsp_lane_align #(.DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W), .LEN_W(LEN_W)) u_align (
        .ofs_i     (ofs_q),
        .len_i     (len_q),
        .st_data_i (st_data_i),
        .rd_row_i  (rd_row),
        .be_o      (be),
        .wr_row_o  (wr_row),
        .ld_data_o (aligned),
        .fault_o   (fault)
    );

    lsp_row_mem #(.DATA_W(DATA_W), .ROWS(ROWS), .LANES(LANES), .ROW_W(ROW_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en_i  (rd_en),
        .wr_en_i  (wr_en),
        .row_i    (row_q),
        .be_i     (be),
        .wr_row_i (wr_row),
        .rd_row_o (rd_row)
    );

    assign ld_data_o = ld_vld_o ? aligned : '0;

endmodule

// File: tb/test_lsport_mem_adapter.sv
`timescale 1ns/1ps
module test_lsport_mem_adapter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_req_i = 1'b0, st_req_i = 1'b0, virt_i = 1'b0;
    logic [3:0]  len_i = '0;
    logic [47:0] addr_i = '0;
    logic        addr_vld_i = 1'b0, st_vld_i = 1'b0;
    logic [63:0] st_data_i = '0;
    logic        busy_o, addr_ack_o, ld_vld_o, exc_o, virt_o;
    logic [63:0] ld_data_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [16][8];

    always #(CLK_PERIOD/2) clk = ~clk;

    lsport_mem_adapter i_lsport_mem_adapter (
        .clk(clk), .rst_n(rst_n), .ld_req_i(ld_req_i), .st_req_i(st_req_i),
        .len_i(len_i), .virt_i(virt_i), .addr_i(addr_i), .addr_vld_i(addr_vld_i),
        .st_data_i(st_data_i), .st_vld_i(st_vld_i), .busy_o(busy_o),
        .addr_ack_o(addr_ack_o), .ld_data_o(ld_data_o), .ld_vld_o(ld_vld_o),
        .exc_o(exc_o), .virt_o(virt_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] len_mask(input int len);
        return (len >= 8) ? 64'hffff_ffff_ffff_ffff : ((64'd1 << (8*len)) - 64'd1);
    endfunction

    function automatic logic [63:0] model_row(input int r);
        logic [63:0] v;
        for (int b = 0; b < 8; b++) v[8*b +: 8] = model[r][b];
        return v;
    endfunction

    task automatic wait_ack();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!addr_ack_o && n < 20);
        chk(addr_ack_o === 1'b1, "R2 ack", {63'd0, addr_ack_o}, 64'd1);
        chk(busy_o === 1'b1, "R2 busy", {63'd0, busy_o}, 64'd1);
    endtask

    task automatic release_port();
        repeat (2) begin
            @(negedge clk);
            chk(busy_o === 1'b1, "R7 held", {63'd0, busy_o}, 64'd1);
        end
        ld_req_i = 1'b0; st_req_i = 1'b0; addr_vld_i = 1'b0;
        @(negedge clk);
        chk(busy_o === 1'b0, "R7 release", {63'd0, busy_o}, 64'd0);
    endtask

    task automatic do_load(input logic [47:0] addr, input int len, input bit virt,
                           input bit exp_fault, input logic [63:0] exp, input string req);
        ld_req_i = 1'b1; len_i = 4'(len); addr_i = addr; addr_vld_i = 1'b1; virt_i = virt;
        wait_ack();
        chk(virt_o === virt, "R8 virt", {63'd0, virt_o}, {63'd0, virt});
        virt_i = ~virt;
        @(negedge clk);
        if (exp_fault) begin
            chk(exc_o === 1'b1 && ld_vld_o === 1'b0, "R6 load exc", {62'd0, exc_o, ld_vld_o}, 64'd2);
            @(negedge clk);
            chk(exc_o === 1'b0 && ld_vld_o === 1'b0, "R6 exc pulse", {62'd0, exc_o, ld_vld_o}, 64'd0);
        end else begin
            chk(ld_vld_o === 1'b0 && exc_o === 1'b0 && ld_data_o === '0, "R4 early",
                {63'd0, ld_vld_o}, 64'd0);
            @(negedge clk);
            chk(ld_vld_o === 1'b1, "R4 valid", {63'd0, ld_vld_o}, 64'd1);
            chk(ld_data_o === exp, req, ld_data_o, exp);
            chk(virt_o === virt, "R8 held", {63'd0, virt_o}, {63'd0, virt});
            @(negedge clk);
            chk(ld_vld_o === 1'b0 && ld_data_o === '0, "R4 pulse", ld_data_o, 64'd0);
        end
        release_port();
    endtask

    task automatic do_store(input logic [47:0] addr, input int len, input logic [63:0] data,
                            input bit exp_fault);
        st_req_i = 1'b1; len_i = 4'(len); addr_i = addr; addr_vld_i = 1'b1; virt_i = 1'b0;
        wait_ack();
        st_data_i = data; st_vld_i = 1'b1;
        @(negedge clk);
        st_vld_i = 1'b0; st_data_i = 64'hdead_dead_dead_dead;
        chk(exc_o === exp_fault, "R6 store exc", {63'd0, exc_o}, {63'd0, exp_fault});
        release_port();
        if (!exp_fault) begin
            for (int b = 0; b < len; b++)
                model[int'(addr[6:3])][int'(addr[2:0]) + b] = data[8*b +: 8];
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < 16; r++)
            for (int b = 0; b < 8; b++) model[r][b] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs
        chk(busy_o === 1'b0 && addr_ack_o === 1'b0 && ld_vld_o === 1'b0 && exc_o === 1'b0,
            "R1 outputs", {60'd0, busy_o, addr_ack_o, ld_vld_o, exc_o}, 64'd0);
        // R1 memory cleared
        for (int r = 0; r < 16; r++)
            do_load(48'(r * 8), 8, r[0], 1'b0, 64'd0, "R1 zero row");

        // R5 little-endian halfwords
        do_store(48'h4, 2, 64'hbeef, 1'b0);
        do_store(48'h6, 2, 64'hf00f, 1'b0);
        do_load(48'h4, 2, 1'b0, 1'b0, 64'hbeef, "R5 half0");
        do_load(48'h6, 2, 1'b1, 1'b0, 64'hf00f, "R5 half1");
        do_load(48'h4, 4, 1'b0, 1'b0, 64'hf00fbeef, "R5 word");

        // R3 R4 R6 sweep over offset and length
        for (int ofs = 0; ofs < 8; ofs++) begin
            for (int li = 0; li < 4; li++) begin
                int len = 1 << li;
                int row = 2 + ((ofs * 4 + li) % 14);
                bit flt = (ofs + len) > 8;
                logic [63:0] pat = {8{8'(8'h11 * (li + 1) + ofs * 8'h20)}} ^ 64'h0807_0605_0403_0201;
                logic [47:0] a = 48'(row * 8 + ofs);
                do_store(a, len, pat, flt);
                do_load(48'(row * 8), 8, 1'b0, 1'b0, model_row(row), "R3 row");
                do_load(a, len, 1'b1, flt, pat & len_mask(len), "R4 sweep");
            end
        end

        // R6 illegal length leaves memory untouched
        do_store(48'h18, 3, 64'hffff_ffff_ffff_ffff, 1'b1);
        do_load(48'h18, 8, 1'b0, 1'b0, model_row(3), "R6 len3 unchanged");
        do_load(48'h18, 6, 1'b0, 1'b1, 64'd0, "R6 len6 load");

        // R9 aliasing of high address bits
        do_store(48'h8000_0000_0010, 8, 64'h0123_4567_89ab_cdef, 1'b0);
        do_load(48'h10, 8, 1'b0, 1'b0, 64'h0123_4567_89ab_cdef, "R9 alias");
        do_load(48'h0000_1234_0012, 2, 1'b0, 1'b0, 64'h89ab, "R9 alias half");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule